// File: doc/BRIEF.md
# Multi-format pixel port unpacker

This block takes a 16-bit word from a pixel bus on every rising edge of the pixel clock and rebuilds whole pixels from it according to a four-bit format code. Each format leaves behind either an 8-bit palette index or a 24-bit direct colour value `{R,G,B}`. Some formats need one word per pixel. Some need two successive words, either as byte pairs or as nibble pairs. One format spreads two 24-bit pixels across three words. Another format packs two indices into a single word, so a second output lane carries the later of the two.

Two format codes are supplied at the same time, a primary and a secondary. The mix select input chooses between them at every pixel boundary. The active-video input marks the visible part of a line. While it is low, nothing is emitted and the word-assembly phase is held at its start. On the first edge with it high, a new pixel group begins.

All outputs are registered. The data lanes, the valid strobes, the index/direct tag and the mix-error flag change together, one edge after the word that completes a pixel.

Top module: `pixel_unpacker`

## Requirements
- R1: Reset (rstN low) clears validFirst, validSecond and errMix. The first edge after reset release still shows them low.
- R2: At a pixel boundary, mixSel=1 selects secondaryMode and mixSel=0 selects primaryMode.
- R3: Code 0 emits index pixIn[7:0]. Code 2 emits R={pixIn[14:10],000}, G={pixIn[9:5],000}, B={pixIn[4:0],000}. Code 3 emits R={pixIn[15:11],000}, G={pixIn[10:5],00}, B={pixIn[4:0],000}. An index output has pixFirst[23:8]=0 and isIndex=1. A direct output is {R,G,B} with isIndex=0.
- R4: Code 1 emits the code-2 direct colour when pixIn[15]=1. Otherwise it emits index pixIn[7:0].
- R5: Code 4 uses two words. Word one gives G in bits 15:8 and B in bits 7:0. Word two gives R in bits 7:0.
- R6: Code 5 emits index pixIn[7:0] on pixFirst and index pixIn[15:8] on pixSecond, with both valids high.
- R7: Codes 6 and 8 use two bytes on pixIn[7:0]. For code 6, byte one = {G4:G2,B7:B3} and byte two = {R7:R3,G7:G5}. For code 8, byte one = {G5:G3,B7:B3} and byte two = {x,R7:R3,G7:G6}. Missing low bits are zero.
- R8: Code 7 builds index {second pixIn[3:0], first pixIn[3:0]}.
- R9: Code 9 takes three words W1..W3. After W2 it emits R=W2[7:0], G=W1[15:8], B=W1[7:0]. After W3 it emits R=W3[15:8], G=W3[7:0], B=W2[15:8].
- R10: While activeIn is low, no valid or error is emitted and any partly built pixel is dropped. The first edge with activeIn high starts a new group.
- R11: If mixSel differs, at a non-boundary edge, from its value at the start of the pixel, errMix pulses with that edge's outputs. The pixel is finished in the old format, and the new one applies from the next boundary.
- R12: Codes 10 to 15 behave as code 0.
- R13: Outputs appear one edge after the completing word. Non-final words of a multi-word pixel emit no valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| activeIn | input | 1 | High during active video, low while blanking |
| mixSel | input | 1 | Chooses the secondary (1) or primary (0) format |
| primaryMode | input | 4 | Primary format code |
| secondaryMode | input | 4 | Secondary format code |
| pixIn | input | 16 | Pixel bus word |
| pixFirst | output | 24 | First (or only) rebuilt pixel |
| pixSecond | output | 24 | Second index of a dual-index word |
| validFirst | output | 1 | pixFirst holds a new pixel |
| validSecond | output | 1 | pixSecond holds a new pixel |
| isIndex | output | 1 | pixFirst is an index (1) or direct colour (0) |
| errMix | output | 1 | Mix select changed inside a pixel |

## Verification
Completing a pixel and flagging a mid-pixel mix change can fall on the same edge. This happens when mixSel flips on the last word of a two-word pixel. The directed case does exactly that in the byte-pair colour format. It expects errMix high together with a pixel built entirely in the old format, and then a pixel in the new format on the following word. The random phase flips mixSel at arbitrary edges across every format pair. A bench reference model judges each edge independently.

// File: rtl/pixunpack_pkg.sv
package pixunpack_pkg;

  localparam int WORD_W  = 16;
  localparam int CHAN_W  = 8;
  localparam int PIX_W   = 3 * CHAN_W;
  localparam int CODE_W  = 4;
  localparam int PHASE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    FMT_IDX8    = 4'd0,
    FMT_MIX15   = 4'd1,
    FMT_D555    = 4'd2,
    FMT_D565    = 4'd3,
    FMT_D24PAIR = 4'd4,
    FMT_IDXDUAL = 4'd5,
    FMT_B565    = 4'd6,
    FMT_NIB     = 4'd7,
    FMT_B555    = 4'd8,
    FMT_D24TRI  = 4'd9
  } fmt_e;

  typedef struct packed {
    logic                loadFirst;
    logic                loadSecond;
    logic                emitFirst;
    logic                emitSecond;
    logic                mixErr;
    logic [PHASE_W-1:0]  phase;
    fmt_e                fmt;
  } ctrlStrobe_t;

  function automatic fmt_e sanitizeFmt(input logic [CODE_W-1:0] code);
    if (code > 4'd9) return FMT_IDX8;
    return fmt_e'(code);
  endfunction

  function automatic logic [PHASE_W-1:0] groupLen(input fmt_e f);
    case (f)
      FMT_D24PAIR, FMT_B565, FMT_NIB, FMT_B555: return 2'd2;
      FMT_D24TRI:                                return 2'd3;
      default:                                   return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pixunpack_control.sv
module pixunpack_control
  import pixunpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              activeIn,
  input  logic              mixSel,
  input  logic [CODE_W-1:0] primaryMode,
  input  logic [CODE_W-1:0] secondaryMode,
  output ctrlStrobe_t       ctrl
);

  logic [PHASE_W-1:0] phaseQ;
  fmt_e               fmtQ;
  logic               mixQ;
  fmt_e               reqFmt;
  fmt_e               curFmt;
  logic               atBoundary;
  logic [PHASE_W-1:0] lastPhase;

  always_comb begin
    reqFmt     = sanitizeFmt(mixSel ? secondaryMode : primaryMode);
    atBoundary = (phaseQ == '0);
    curFmt     = atBoundary ? reqFmt : fmtQ;
    lastPhase  = groupLen(curFmt) - 2'd1;

    ctrl.fmt        = curFmt;
    ctrl.phase      = phaseQ;
    ctrl.loadFirst  = activeIn && atBoundary;
    ctrl.loadSecond = activeIn && (phaseQ == 2'd1);
    ctrl.emitFirst  = activeIn && ((phaseQ == lastPhase) ||
                                   ((curFmt == FMT_D24TRI) && (phaseQ == 2'd1)));
    ctrl.emitSecond = activeIn && (curFmt == FMT_IDXDUAL);
    ctrl.mixErr     = activeIn && !atBoundary && (mixSel != mixQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      fmtQ   <= FMT_IDX8;
      mixQ   <= 1'b0;
    end else if (!activeIn) begin
      phaseQ <= '0;
    end else begin
      if (atBoundary) begin
        fmtQ <= curFmt;
        mixQ <= mixSel;
      end
      phaseQ <= (phaseQ == lastPhase) ? '0 : phaseQ + 2'd1;
    end
  end

endmodule

// File: rtl/pixunpack_datapath.sv
module pixunpack_datapath
  import pixunpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] pixIn,
  input  ctrlStrobe_t       ctrl,
  output logic [PIX_W-1:0]  pixFirst,
  output logic [PIX_W-1:0]  pixSecond,
  output logic              validFirst,
  output logic              validSecond,
  output logic              isIndex,
  output logic              errMix
);

  localparam int PAD_W = PIX_W - CHAN_W;

  logic [WORD_W-1:0] word0Q;
  logic [WORD_W-1:0] word1Q;
  logic [PIX_W-1:0]  firstD;
  logic [PIX_W-1:0]  secondD;
  logic              indexD;
  logic [PIX_W-1:0]  d555;

  always_comb begin
    d555    = {pixIn[14:10], 3'b0, pixIn[9:5], 3'b0, pixIn[4:0], 3'b0};
    firstD  = '0;
    secondD = '0;
    indexD  = 1'b0;
    case (ctrl.fmt)
      FMT_IDX8: begin
        firstD = {{PAD_W{1'b0}}, pixIn[7:0]};
        indexD = 1'b1;
      end
      FMT_MIX15: begin
        if (pixIn[15]) firstD = d555;
        else begin
          firstD = {{PAD_W{1'b0}}, pixIn[7:0]};
          indexD = 1'b1;
        end
      end
      FMT_D555:    firstD = d555;
      FMT_D565:    firstD = {pixIn[15:11], 3'b0, pixIn[10:5], 2'b0, pixIn[4:0], 3'b0};
      FMT_D24PAIR: firstD = {pixIn[7:0], word0Q};
      FMT_IDXDUAL: begin
        firstD  = {{PAD_W{1'b0}}, pixIn[7:0]};
        secondD = {{PAD_W{1'b0}}, pixIn[15:8]};
        indexD  = 1'b1;
      end
      FMT_B565: firstD = {pixIn[7:3], 3'b0, pixIn[2:0], word0Q[7:5], 2'b0,
                          word0Q[4:0], 3'b0};
      FMT_NIB: begin
        firstD = {{PAD_W{1'b0}}, pixIn[3:0], word0Q[3:0]};
        indexD = 1'b1;
      end
      FMT_B555: firstD = {pixIn[6:2], 3'b0, pixIn[1:0], word0Q[7:5], 3'b0,
                          word0Q[4:0], 3'b0};
      FMT_D24TRI: begin
        if (ctrl.phase == 2'd1) firstD = {pixIn[7:0], word0Q};
        else                    firstD = {pixIn[15:8], pixIn[7:0], word1Q[15:8]};
      end
      default: firstD = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0Q      <= '0;
      word1Q      <= '0;
      pixFirst    <= '0;
      pixSecond   <= '0;
      validFirst  <= 1'b0;
      validSecond <= 1'b0;
      isIndex     <= 1'b0;
      errMix      <= 1'b0;
    end else begin
      validFirst  <= ctrl.emitFirst;
      validSecond <= ctrl.emitSecond;
      errMix      <= ctrl.mixErr;
      if (ctrl.loadFirst)  word0Q <= pixIn;
      if (ctrl.loadSecond) word1Q <= pixIn;
      if (ctrl.emitFirst) begin
        pixFirst <= firstD;
        isIndex  <= indexD;
      end
      if (ctrl.emitSecond) pixSecond <= secondD;
    end
  end

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pixunpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              activeIn,
  input  logic              mixSel,
  input  logic [CODE_W-1:0] primaryMode,
  input  logic [CODE_W-1:0] secondaryMode,
  input  logic [WORD_W-1:0] pixIn,
  output logic [PIX_W-1:0]  pixFirst,
  output logic [PIX_W-1:0]  pixSecond,
  output logic              validFirst,
  output logic              validSecond,
  output logic              isIndex,
  output logic              errMix
);

  ctrlStrobe_t ctrl;

  pixunpack_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .activeIn      (activeIn),
    .mixSel        (mixSel),
    .primaryMode   (primaryMode),
    .secondaryMode (secondaryMode),
    .ctrl          (ctrl)
  );

  pixunpack_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pixIn       (pixIn),
    .ctrl        (ctrl),
    .pixFirst    (pixFirst),
    .pixSecond   (pixSecond),
    .validFirst  (validFirst),
    .validSecond (validSecond),
    .isIndex     (isIndex),
    .errMix      (errMix)
  );

endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        activeIn,
  input logic [23:0] pixFirst,
  input logic        validFirst,
  input logic        validSecond,
  input logic        isIndex,
  input logic        errMix
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!validFirst && !validSecond && !errMix));

  p_blank_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    !activeIn |=> (!validFirst && !validSecond && !errMix));

  p_second_with_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    validSecond |-> (validFirst && isIndex));

  p_index_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (validFirst && isIndex) |-> (pixFirst[23:8] == 16'h0));

  p_err_not_dual_r11: assert property (@(posedge clk) disable iff (!rstN)
    errMix |-> !validSecond);

  p_err_needs_active_r11: assert property (@(posedge clk) disable iff (!rstN)
    errMix |-> $past(activeIn));

endmodule

bind pixel_unpacker pixel_unpacker_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .activeIn    (activeIn),
  .pixFirst    (pixFirst),
  .validFirst  (validFirst),
  .validSecond (validSecond),
  .isIndex     (isIndex),
  .errMix      (errMix)
);

// File: tb/pixel_unpacker_tb.sv
module pixel_unpacker_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        activeIn;
  logic        mixSel;
  logic [3:0]  priMode;
  logic [3:0]  secMode;
  logic [15:0] pixIn;
  logic [23:0] pixFirst;
  logic [23:0] pixSecond;
  logic        validFirst;
  logic        validSecond;
  logic        isIndex;
  logic        errMix;

  int nCmp = 0;
  int nBad = 0;

  int          mPhase = 0;
  int          mFmt   = 0;
  bit          mMix   = 1'b0;
  logic [15:0] mW0    = '0;
  logic [15:0] mW1    = '0;

  always #4 clk = ~clk;

  pixel_unpacker u_dut (
    .clk(clk), .rstN(rstN), .activeIn(activeIn), .mixSel(mixSel),
    .primaryMode(priMode), .secondaryMode(secMode), .pixIn(pixIn),
    .pixFirst(pixFirst), .pixSecond(pixSecond), .validFirst(validFirst),
    .validSecond(validSecond), .isIndex(isIndex), .errMix(errMix)
  );

  function automatic int sanit(input logic [3:0] c);
    return (c > 4'd9) ? 0 : int'(c);
  endfunction

  function automatic int glen(input int f);
    if (f == 4 || f == 6 || f == 7 || f == 8) return 2;
    if (f == 9) return 3;
    return 1;
  endfunction

  task automatic step(input logic [15:0] w, input bit mix, input bit act, input string tag);
    bit eA = 0, eB = 0, eErr = 0, eIdx = 0;
    logic [23:0] dA = '0, dB = '0;
    int f;
    @(negedge clk);
    pixIn = w; mixSel = mix; activeIn = act;
    if (!act) mPhase = 0;
    else begin
      f = (mPhase == 0) ? sanit(mix ? secMode : priMode) : mFmt;
      if (mPhase != 0 && mix != mMix) eErr = 1;
      if (mPhase == 0) begin mFmt = f; mMix = mix; end
      case (f)
        0: begin eA = 1; eIdx = 1; dA = {16'h0, w[7:0]}; end
        1: begin
          eA = 1;
          if (w[15]) dA = {w[14:10], 3'b0, w[9:5], 3'b0, w[4:0], 3'b0};
          else begin eIdx = 1; dA = {16'h0, w[7:0]}; end
        end
        2: begin eA = 1; dA = {w[14:10], 3'b0, w[9:5], 3'b0, w[4:0], 3'b0}; end
        3: begin eA = 1; dA = {w[15:11], 3'b0, w[10:5], 2'b0, w[4:0], 3'b0}; end
        4: if (mPhase == 1) begin eA = 1; dA = {w[7:0], mW0[15:8], mW0[7:0]}; end
        5: begin eA = 1; eB = 1; eIdx = 1; dA = {16'h0, w[7:0]}; dB = {16'h0, w[15:8]}; end
        6: if (mPhase == 1) begin
          eA = 1;
          dA = {w[7:3], 3'b0, w[2:0], mW0[7:5], 2'b0, mW0[4:0], 3'b0};
        end
        7: if (mPhase == 1) begin eA = 1; eIdx = 1; dA = {16'h0, w[3:0], mW0[3:0]}; end
        8: if (mPhase == 1) begin
          eA = 1;
          dA = {w[6:2], 3'b0, w[1:0], mW0[7:5], 3'b0, mW0[4:0], 3'b0};
        end
        default: begin
          if (mPhase == 1) begin eA = 1; dA = {w[7:0], mW0[15:8], mW0[7:0]}; end
          if (mPhase == 2) begin eA = 1; dA = {w[15:8], w[7:0], mW1[15:8]}; end
        end
      endcase
      if (mPhase == 0) mW0 = w;
      if (mPhase == 1) mW1 = w;
      mPhase = (mPhase == glen(f) - 1) ? 0 : mPhase + 1;
    end
    @(posedge clk); #2;
    nCmp++;
    if (validFirst !== eA || validSecond !== eB || errMix !== eErr ||
        (eA && (pixFirst !== dA || isIndex !== eIdx)) || (eB && pixSecond !== dB)) begin
      nBad++;
      $display("FAIL %s: actual vA=%b vB=%b err=%b idx=%b a=%h b=%h expected vA=%b vB=%b err=%b idx=%b a=%h b=%h",
               tag, validFirst, validSecond, errMix, isIndex, pixFirst, pixSecond,
               eA, eB, eErr, eIdx, dA, dB);
    end
  endtask

  initial begin
    #(8 * 200000);
    nCmp++; nBad++;
    $display("FAIL R13 watchdog: actual still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    rstN = 1'b0; activeIn = 1'b0; mixSel = 1'b0; priMode = 4'd0; secMode = 4'd0; pixIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    nCmp++;
    if (validFirst !== 1'b0 || validSecond !== 1'b0 || errMix !== 1'b0) begin
      nBad++;
      $display("FAIL R1: actual vA=%b vB=%b err=%b expected 0 0 0", validFirst, validSecond, errMix);
    end

    // R3 single-word formats
    priMode = 4'd0; step(16'hAB5C, 0, 1, "R3");
    priMode = 4'd2; step(16'h7C1F, 0, 1, "R3");
    priMode = 4'd3; step(16'hF81F, 0, 1, "R3");
    // R2 primary/secondary selection
    priMode = 4'd3; secMode = 4'd0;
    step(16'h1234, 1, 1, "R2"); step(16'h1234, 0, 1, "R2");
    // R4 mixed format
    priMode = 4'd1; step(16'h8123, 0, 1, "R4"); step(16'h0156, 0, 1, "R4");
    // R5 and R13 two-word direct
    priMode = 4'd4; step(16'h1234, 0, 1, "R13"); step(16'h0056, 0, 1, "R5");
    // R6 dual index
    priMode = 4'd5; step(16'hA55A, 0, 1, "R6");
    // R7 byte pairs
    priMode = 4'd6; step(16'h00E7, 0, 1, "R7"); step(16'h00B5, 0, 1, "R7");
    priMode = 4'd8; step(16'h00A9, 0, 1, "R7"); step(16'h00FE, 0, 1, "R7");
    // R8 nibbles
    priMode = 4'd7; step(16'h0005, 0, 1, "R8"); step(16'hFFFC, 0, 1, "R8");
    // R9 three words, two pixels
    priMode = 4'd9;
    step(16'h1122, 0, 1, "R9"); step(16'h3344, 0, 1, "R9"); step(16'h5566, 0, 1, "R9");
    step(16'hA0B0, 0, 1, "R9"); step(16'hC0D0, 0, 1, "R9"); step(16'hE0F0, 0, 1, "R9");
    // R10 blanking drops partial pixel, restarts phase
    priMode = 4'd4;
    step(16'hDEAD, 0, 1, "R10"); step(16'hBEEF, 0, 0, "R10"); step(16'h0000, 0, 0, "R10");
    step(16'h4321, 0, 1, "R10"); step(16'h0099, 0, 1, "R10");
    // R11 mix change on the completing word
    priMode = 4'd6; secMode = 4'd0;
    step(16'h00E7, 0, 1, "R11"); step(16'h00B5, 1, 1, "R11"); step(16'h0077, 1, 1, "R11");
    // R12 out-of-range code
    priMode = 4'd12; step(16'h9876, 0, 1, "R12");
    priMode = 4'd15; step(16'h00C3, 0, 1, "R12");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit rm, ra;
      if (i % 150 == 0) begin priMode = 4'($urandom); secMode = 4'($urandom); end
      rm = ($urandom % 5 == 0) ? ~mixSel : mixSel;
      ra = ($urandom % 16 != 0);
      step(16'($urandom), rm, ra, "R2");
    end

    step(16'h0, 0, 0, "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule